// File: doc/BRIEF.md
# Display RAM Address Generator

This block holds the host-side address into a bitmap display memory of 120 lines by 132 columns. The memory is split into pages of 8 lines each. Each memory byte stores one column of one page, and its bit 0 through bit 7 are eight successive display lines. The block keeps two values: a page register, which changes only when the host sets it, and a column counter, which the host can preset and which advances by one after each data access.

The column counter stops at one past the last real column (0x84). Further accesses leave it there until the host sets a new column. The counter never carries into the page. A mirror setting selects which segment output the current column drives, so a panel can be mounted in either direction.

The block outputs a flat byte address for the memory, a column-valid flag, a write enable that blocks writes at the stopped position, and the segment index. The memory itself and the command decoding sit outside the block.

Top module: `dram_addr_gen`

## Requirements
- R1: A column-set strobe loads the given column value, visible on the next cycle. It wins over an access strobe in the same cycle.
- R2: An access strobe (read or write, `access_wr_i` = 1 for write) with the column below 0x84 and no column set raises the column by exactly one on the next cycle.
- R3: At a column of 0x84 or above (including preset values above 0x84), access strobes leave the column unchanged. Only a column set moves it away.
- R4: Accesses never change the page. The page changes only through a page-set strobe.
- R5: A page-set value of 15 or above is ignored and the previous page is kept. Values 0 to 14 are loaded on the next cycle.
- R6: While the column is valid, the byte address equals page × 132 + column.
- R7: `col_valid_o` is 1 exactly when the column is below 0x84. `mem_we_o` is 1 exactly when an access strobe with `access_wr_i` = 1 arrives while the column is valid.
- R8: The mirror-set strobe loads `mirror_val_i` into `mirror_o` on the next cycle. With mirror 0 the segment equals the column. With mirror 1 it equals 131 − column. It is 0 while the column is not valid.
- R9: While reset is asserted, the next clock edge sets the column to 0, the page to 0 and the mirror to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| page_set_i | input | 1 | Page-set strobe |
| page_val_i | input | 4 | Page value to load |
| col_set_i | input | 1 | Column-set strobe |
| col_val_i | input | 8 | Column value to load |
| access_i | input | 1 | Data access done strobe |
| access_wr_i | input | 1 | 1 when the access is a write |
| mirror_set_i | input | 1 | Mirror-select strobe |
| mirror_val_i | input | 1 | Mirror value: 0 normal, 1 reversed |
| page_o | output | 4 | Current page |
| col_o | output | 8 | Current column |
| byte_addr_o | output | 11 | Flat byte address, page × 132 + column |
| col_valid_o | output | 1 | Column is below 0x84 |
| mem_we_o | output | 1 | Write enable to the display memory |
| seg_o | output | 8 | Segment driven by the current column |
| mirror_o | output | 1 | Current mirror setting |

## Verification
Every strobe updates the page, column or mirror register at the next rising edge. The byte address, valid flag and segment index follow from those registers without further delay, so they are due in the same cycle as the register change. The write enable is combinational from the access strobe, so it is due during the strobe's own cycle. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the following one. It checks `mem_we_o` while the strobe is still applied, before that edge.

// File: rtl/dram_addr_pkg.sv
// Shared types for the display RAM address generator.
// Assumes: single clock domain; consumers import this package.
package dram_addr_pkg;
    typedef enum logic {
        SEG_ORDER_FWD = 1'b0,
        SEG_ORDER_REV = 1'b1
    } seg_order_e;
endpackage

// File: rtl/dram_col_ctr.sv
// Presettable column counter with a saturating stop one past the last column.
// Assumes: load has priority over step; values at or above NUM_COLS are held.
module dram_col_ctr #(
    parameter int COL_W    = 8,
    parameter int NUM_COLS = 132
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [COL_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [COL_W-1:0] col_o,
    output logic             in_range_o
);
    localparam logic [COL_W-1:0] STOP_COL = COL_W'(NUM_COLS);

    logic [COL_W-1:0] col_q;

    // Valid while below the stop value.
    assign in_range_o = (col_q < STOP_COL);
    assign col_o      = col_q;

    // Column register: preset, or advance when in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (load_i) begin
            col_q <= load_val_i;
        end else if (step_i && in_range_o) begin
            col_q <= col_q + 1'b1;
        end
    end
endmodule

// File: rtl/dram_page_reg.sv
// Page register; accepts only page numbers that exist.
// Assumes: out-of-range set values are dropped silently.
module dram_page_reg #(
    parameter int PAGE_W    = 4,
    parameter int NUM_PAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PAGE_W-1:0] load_val_i,
    output logic [PAGE_W-1:0] page_o
);
    localparam logic [PAGE_W-1:0] PAGE_LIMIT = PAGE_W'(NUM_PAGES);

    logic accept;
    logic [PAGE_W-1:0] page_q;

    // Only existing pages are taken.
    assign accept = load_i && (load_val_i < PAGE_LIMIT);
    assign page_o = page_q;

    // Page register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (accept) begin
            page_q <= load_val_i;
        end
    end
endmodule

// File: rtl/dram_seg_map.sv
// Holds the mirror setting and maps the current column to a segment index.
// Assumes: segment reported as zero when the column is out of range.
module dram_seg_map
    import dram_addr_pkg::*;
#(
    parameter int COL_W    = 8,
    parameter int NUM_COLS = 132
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             val_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             in_range_i,
    output logic [COL_W-1:0] seg_o,
    output seg_order_e       order_o
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    seg_order_e order_q;

    assign order_o = order_q;

    // Mirror setting register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= SEG_ORDER_FWD;
        end else if (set_i) begin
            order_q <= seg_order_e'(val_i);
        end
    end

    // Column to segment mapping.
    always_comb begin
        if (!in_range_i) begin
            seg_o = '0;
        end else if (order_q == SEG_ORDER_REV) begin
            seg_o = LAST_COL - col_i;
        end else begin
            seg_o = col_i;
        end
    end
endmodule

// File: rtl/dram_byte_addr.sv
// Flattens page and column into a linear byte address.
// Assumes: ADDR_W covers NUM_PAGES*NUM_COLS.
module dram_byte_addr #(
    parameter int PAGE_W   = 4,
    parameter int COL_W    = 8,
    parameter int NUM_COLS = 132,
    parameter int ADDR_W   = 11
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] ROW_BYTES = ADDR_W'(NUM_COLS);

    // Linear address: page stride plus column.
    always_comb begin
        addr_o = (ADDR_W'(page_i) * ROW_BYTES) + ADDR_W'(col_i);
    end
endmodule

// File: rtl/dram_addr_gen.sv
// Top of the display RAM address generator: page register, column counter,
// byte address and segment mapping, plus the write gate at the stop column.
// Assumes: strobes are single-cycle and synchronous to clk.
module dram_addr_gen
    import dram_addr_pkg::*;
#(
    parameter int NUM_PAGES = 15,
    parameter int NUM_COLS  = 132,
    parameter int PAGE_W    = 4,
    parameter int COL_W     = 8,
    parameter int ADDR_W    = $clog2(NUM_PAGES * NUM_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_set_i,
    input  logic [PAGE_W-1:0] page_val_i,
    input  logic              col_set_i,
    input  logic [COL_W-1:0]  col_val_i,
    input  logic              access_i,
    input  logic              access_wr_i,
    input  logic              mirror_set_i,
    input  logic              mirror_val_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [COL_W-1:0]  col_o,
    output logic [ADDR_W-1:0] byte_addr_o,
    output logic              col_valid_o,
    output logic              mem_we_o,
    output logic [COL_W-1:0]  seg_o,
    output logic              mirror_o
);
    seg_order_e order;

    dram_page_reg #(.PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)) u_page (
        .clk(clk), .rst_n(rst_n), .load_i(page_set_i),
        .load_val_i(page_val_i), .page_o(page_o)
    );

    dram_col_ctr #(.COL_W(COL_W), .NUM_COLS(NUM_COLS)) u_col (
        .clk(clk), .rst_n(rst_n), .load_i(col_set_i), .load_val_i(col_val_i),
        .step_i(access_i), .col_o(col_o), .in_range_o(col_valid_o)
    );

    dram_byte_addr #(.PAGE_W(PAGE_W), .COL_W(COL_W), .NUM_COLS(NUM_COLS),
                     .ADDR_W(ADDR_W)) u_addr (
        .page_i(page_o), .col_i(col_o), .addr_o(byte_addr_o)
    );

    dram_seg_map #(.COL_W(COL_W), .NUM_COLS(NUM_COLS)) u_seg (
        .clk(clk), .rst_n(rst_n), .set_i(mirror_set_i), .val_i(mirror_val_i),
        .col_i(col_o), .in_range_i(col_valid_o), .seg_o(seg_o), .order_o(order)
    );

    // Mirror state as a plain bit.
    assign mirror_o = (order == SEG_ORDER_REV);

    // Writes pass only while the column is real.
    assign mem_we_o = access_i && access_wr_i && col_valid_o;
endmodule

// File: rtl/dram_addr_gen_chk.sv
// Property checker for dram_addr_gen, attached by bind.
module dram_addr_gen_chk #(
    parameter int NUM_PAGES = 15,
    parameter int NUM_COLS  = 132,
    parameter int PAGE_W    = 4,
    parameter int COL_W     = 8,
    parameter int ADDR_W    = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              page_set_i,
    input logic [PAGE_W-1:0] page_val_i,
    input logic              col_set_i,
    input logic [COL_W-1:0]  col_val_i,
    input logic              access_i,
    input logic              access_wr_i,
    input logic              mirror_set_i,
    input logic              mirror_val_i,
    input logic [PAGE_W-1:0] page_o,
    input logic [COL_W-1:0]  col_o,
    input logic [ADDR_W-1:0] byte_addr_o,
    input logic              col_valid_o,
    input logic              mem_we_o,
    input logic [COL_W-1:0]  seg_o,
    input logic              mirror_o
);
    localparam logic [COL_W-1:0]  STOP_COL   = COL_W'(NUM_COLS);
    localparam logic [PAGE_W-1:0] PAGE_LIMIT = PAGE_W'(NUM_PAGES);
    localparam logic [ADDR_W-1:0] ADDR_TOP   = ADDR_W'(NUM_PAGES * NUM_COLS);

    // R1
    col_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_set_i |=> (col_o == $past(col_val_i)));

    // R2
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && !col_set_i && (col_o < STOP_COL)) |=>
        (col_o == COL_W'($past(col_o) + 1'b1)));

    // R3
    col_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_set_i && (col_o >= STOP_COL)) |=> $stable(col_o));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !page_set_i |=> $stable(page_o));

    // R5
    page_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_set_i && (page_val_i >= PAGE_LIMIT)) |=> $stable(page_o));

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o |-> (byte_addr_o < ADDR_TOP));

    // R7
    we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (access_i && access_wr_i && (col_o < STOP_COL)));

    // R8
    mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_set_i |=> (mirror_o == $past(mirror_val_i)));

    // R8
    seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_o < STOP_COL);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> ((col_o == '0) && (page_o == '0) && !mirror_o));
endmodule

bind dram_addr_gen dram_addr_gen_chk #(
    .NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS), .PAGE_W(PAGE_W),
    .COL_W(COL_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .page_set_i(page_set_i), .page_val_i(page_val_i),
    .col_set_i(col_set_i), .col_val_i(col_val_i), .access_i(access_i),
    .access_wr_i(access_wr_i), .mirror_set_i(mirror_set_i),
    .mirror_val_i(mirror_val_i), .page_o(page_o), .col_o(col_o),
    .byte_addr_o(byte_addr_o), .col_valid_o(col_valid_o), .mem_we_o(mem_we_o),
    .seg_o(seg_o), .mirror_o(mirror_o)
);

// File: tb/dram_addr_gen_tb.sv
module dram_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_set_i = 1'b0;
    logic [3:0]  page_val_i = '0;
    logic        col_set_i = 1'b0;
    logic [7:0]  col_val_i = '0;
    logic        access_i = 1'b0;
    logic        access_wr_i = 1'b0;
    logic        mirror_set_i = 1'b0;
    logic        mirror_val_i = 1'b0;
    logic [3:0]  page_o;
    logic [7:0]  col_o;
    logic [10:0] byte_addr_o;
    logic        col_valid_o;
    logic        mem_we_o;
    logic [7:0]  seg_o;
    logic        mirror_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .page_set_i(page_set_i), .page_val_i(page_val_i),
        .col_set_i(col_set_i), .col_val_i(col_val_i), .access_i(access_i),
        .access_wr_i(access_wr_i), .mirror_set_i(mirror_set_i),
        .mirror_val_i(mirror_val_i), .page_o(page_o), .col_o(col_o),
        .byte_addr_o(byte_addr_o), .col_valid_o(col_valid_o), .mem_we_o(mem_we_o),
        .seg_o(seg_o), .mirror_o(mirror_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_page(int p);
        page_set_i = 1'b1; page_val_i = 4'(p);
        step();
        page_set_i = 1'b0;
    endtask

    task automatic set_col(int c);
        col_set_i = 1'b1; col_val_i = 8'(c);
        step();
        col_set_i = 1'b0;
    endtask

    task automatic set_mirror(bit m);
        mirror_set_i = 1'b1; mirror_val_i = m;
        step();
        mirror_set_i = 1'b0;
    endtask

    initial begin
        int exp_page;
        int exp_col;
        repeat (3) step();
        // R9: reset state
        chk("R9 col", col_o, 0);
        chk("R9 page", page_o, 0);
        chk("R9 mirror", mirror_o, 0);
        rst_n = 1'b1;
        step();
        chk("R9 seg", seg_o, 0);
        chk("R6 addr after reset", byte_addr_o, 0);

        // Sweep: both mirror settings, every page value, every column around the stop
        exp_page = 0;
        for (int m = 0; m < 2; m++) begin
            set_mirror(m[0]);
            chk("R8 mirror load", mirror_o, m);
            for (int p = 0; p < 16; p++) begin
                set_page(p);
                if (p < 15) exp_page = p;
                chk("R5 page set", page_o, exp_page);
                for (int c = 0; c < 134; c++) begin
                    set_col(c);
                    chk("R1 col load", col_o, c);
                    chk("R4 page kept", page_o, exp_page);
                    chk("R7 valid", col_valid_o, (c < 132) ? 1 : 0);
                    if (c < 132) begin
                        chk("R6 byte addr", byte_addr_o, exp_page * 132 + c);
                        chk("R8 segment", seg_o, (m == 1) ? 131 - c : c);
                    end else begin
                        chk("R8 segment invalid", seg_o, 0);
                    end
                end
            end
        end
        set_mirror(1'b0);

        // R2/R3/R7: write accesses from column 0 up past the stop
        set_page(3);
        set_col(0);
        exp_col = 0;
        for (int i = 0; i < 140; i++) begin
            access_i = 1'b1; access_wr_i = 1'b1;
            #0.5;
            chk("R7 write enable", mem_we_o, (exp_col < 132) ? 1 : 0);
            step();
            if (exp_col < 132) exp_col++;
            chk((exp_col < 132) ? "R2 step" : "R3 stop", col_o, exp_col);
            chk("R4 page unchanged by access", page_o, 3);
        end
        access_i = 1'b0; access_wr_i = 1'b0;

        // R3: reads at the stop still hold; a column set releases
        access_i = 1'b1;
        #0.5;
        chk("R7 read no write", mem_we_o, 0);
        step();
        access_i = 1'b0;
        chk("R3 read at stop", col_o, 132);
        set_col(5);
        chk("R3 release by set", col_o, 5);
        access_i = 1'b1;
        #0.5;
        chk("R7 read gives no write", mem_we_o, 0);
        step();
        access_i = 1'b0;
        chk("R2 read steps", col_o, 6);

        // R1: set and access in the same cycle
        col_set_i = 1'b1; col_val_i = 8'd10; access_i = 1'b1; access_wr_i = 1'b1;
        step();
        col_set_i = 1'b0; access_i = 1'b0; access_wr_i = 1'b0;
        chk("R1 set wins", col_o, 10);

        // R3: preset above the stop holds on access
        set_col(200);
        access_i = 1'b1; access_wr_i = 1'b1;
        #0.5;
        chk("R7 no write above stop", mem_we_o, 0);
        step();
        access_i = 1'b0; access_wr_i = 1'b0;
        chk("R3 above stop hold", col_o, 200);
        chk("R7 invalid above stop", col_valid_o, 0);

        // R4/R5: last column access keeps page; bad page value ignored
        set_page(7);
        set_col(131);
        access_i = 1'b1;
        step();
        access_i = 1'b0;
        chk("R3 reaches stop", col_o, 132);
        chk("R4 no carry into page", page_o, 7);
        set_page(15);
        chk("R5 page 15 ignored", page_o, 7);

        // R9: reset mid-run restores defaults
        set_mirror(1'b1);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk("R9 col after reset", col_o, 0);
        chk("R9 page after reset", page_o, 0);
        chk("R9 mirror after reset", mirror_o, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule